// File: doc/BRIEF.md
# Fully Associative Translation Cache with Use and Dirty Tracking

The block caches page translations in a small set of entries, any of which can hold any page. A requester presents a virtual address, a read/write flag and a user/supervisor flag. Every valid entry's virtual page tag is compared with the page number in parallel. One cycle later the block answers with exactly one of hit, miss or protection fault. On a hit it also returns the physical address: the entry's physical page joined to the unchanged page offset.

A clean hit marks the entry as recently used. A clean write hit also marks it dirty. A miss or a fault leaves every entry untouched, so the requester can walk the page table, refill, and retry the same access.

A refill request writes a new translation into a slot that the block picks itself. It prefers the lowest-numbered empty slot. Failing that, it takes the lowest-numbered slot whose use bit is clear. If every use bit is set, it clears them all and takes slot 0. The cycle after a refill, the block reports which slot it took and what that slot held before. A flush input empties the whole table in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: A lookup whose page number matches a valid entry, with no protection violation, gives `rsp_valid_o`=1 and `rsp_hit_o`=1 on the next cycle. In that cycle `rsp_paddr_o` = {entry physical page, vaddr[11:0]}, with the virtual page number taken from vaddr[31:12].
- R2: A lookup that matches no valid entry gives `rsp_miss_o`=1 on the next cycle, with `rsp_paddr_o`=0. It changes no entry's use or dirty bit.
- R3: A protection fault is raised when a matching entry has its supervisor-only flag set and `lkp_user_i`=1, or has its read-only flag set and `lkp_write_i`=1. The fault gives `rsp_fault_o`=1 and `rsp_paddr_o`=0 on the next cycle, and sets neither the use bit nor the dirty bit.
- R4: In a cycle where `rsp_valid_o`=1, exactly one of hit, miss and fault is 1. In a cycle where `rsp_valid_o`=0 (no lookup in the previous cycle), all three are 0.
- R5: A clean hit sets the entry's use bit. A clean hit with `lkp_write_i`=1 also sets its dirty bit. Both bits can be seen in the refill report when the entry is later replaced.
- R6: A refill goes to the lowest-index invalid slot when one exists.
- R7: When every slot is valid, a refill goes to the lowest-index slot whose use bit is 0.
- R8: When every slot is valid and every use bit is 1, a refill clears all use bits and goes to slot 0.
- R9: The cycle after an accepted refill, `fill_ack_o`=1 and `fill_slot_o` gives the chosen slot. `evict_o` tells whether the slot held a valid entry, and `evict_vpn_o`, `evict_ref_o` and `evict_dirty_o` give its old page number, use bit and dirty bit. The new entry starts with use=0 and dirty=0. With no refill in the previous cycle, `fill_ack_o`=0.
- R10: `flush_i` invalidates every entry in one cycle, so later lookups miss. A refill in the same cycle as a flush is dropped: `fill_ack_o` stays 0 and the table stays empty.
- R11: After reset every entry is invalid and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 32 | Virtual address, page number in [31:12] |
| lkp_write_i | input | 1 | 1 = write access, 0 = read |
| lkp_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid_o | output | 1 | Response present (one cycle after lookup) |
| rsp_hit_o | output | 1 | Clean translation hit |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Access rights violated |
| rsp_paddr_o | output | 32 | Physical address on hit, else 0 |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 20 | Refill virtual page number |
| fill_ppn_i | input | 20 | Refill physical page number |
| fill_sup_i | input | 1 | Refill entry is supervisor-only |
| fill_ro_i | input | 1 | Refill entry is read-only |
| flush_i | input | 1 | Invalidate all entries |
| fill_ack_o | output | 1 | Refill report present |
| fill_slot_o | output | 4 | Slot written by the refill |
| evict_o | output | 1 | Replaced slot held a valid entry |
| evict_vpn_o | output | 20 | Page number of replaced entry |
| evict_ref_o | output | 1 | Use bit of replaced entry |
| evict_dirty_o | output | 1 | Dirty bit of replaced entry |

## Verification
The assertions check several rules on every cycle. Each response carries exactly one flag, and an idle cycle carries none. A hit returns the offset of the lookup address unchanged, while a miss or a fault returns a zero address. A flush empties the table, and a refill report appears only after an accepted refill. Only the bench's scenarios show whether the right translation and the right victim slot were chosen, and whether use and dirty bits accumulated correctly. They also show that a miss or a fault left those bits alone; the bench sees all of this through the refill report and compares it with its own model of the table.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_PPN_W   = 20;
  localparam int unsigned DEF_OFF_W   = 12;

  typedef struct packed {
    logic sup;  // supervisor-only
    logic ro;   // read-only
  } perm_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              vpn_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid_i[i] && (tag_i[i] == vpn_i);
  end

  assign hit_o = |match;

  // lowest index wins if tags ever alias
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] use_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               clr_use_o
);
  logic found;

  always_comb begin
    idx_o     = '0;
    found     = 1'b0;
    clr_use_o = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_i[i]) begin
        idx_o = IDX_W'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !use_i[i]) begin
        idx_o = IDX_W'(i);
        found = 1'b1;
      end
    end
    if (!found) clr_use_o = 1'b1;  // all recently used: age everyone, take slot 0
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned PPN_W   = DEF_PPN_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned VA_W   = VPN_W + OFF_W,
  localparam int unsigned PA_W   = PPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [VA_W-1:0]  lkp_vaddr_i,
  input  logic             lkp_write_i,
  input  logic             lkp_user_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_sup_i,
  input  logic             fill_ro_i,
  input  logic             flush_i,
  output logic             fill_ack_o,
  output logic [IDX_W-1:0] fill_slot_o,
  output logic             evict_o,
  output logic [VPN_W-1:0] evict_vpn_o,
  output logic             evict_ref_o,
  output logic             evict_dirty_o
);
  logic [ENTRIES-1:0]            valid_q, use_q, dirty_q;
  perm_t [ENTRIES-1:0]           perm_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

  logic [VPN_W-1:0] lkp_vpn;
  logic             cam_hit;
  logic [IDX_W-1:0] cam_idx;
  logic             viol, acc_ok, acc_fault, acc_miss;
  logic [IDX_W-1:0] vic_idx;
  logic             vic_clr, fill_go;
  logic [ENTRIES-1:0] touch;

  assign lkp_vpn = lkp_vaddr_i[VA_W-1:OFF_W];

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cam (
    .valid_i (valid_q),
    .tag_i   (vpn_q),
    .vpn_i   (lkp_vpn),
    .hit_o   (cam_hit),
    .idx_o   (cam_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
    .valid_i   (valid_q),
    .use_i     (use_q),
    .idx_o     (vic_idx),
    .clr_use_o (vic_clr)
  );

  assign viol      = (perm_q[cam_idx].sup & lkp_user_i) | (perm_q[cam_idx].ro & lkp_write_i);
  assign acc_ok    = lkp_valid_i & cam_hit & ~viol;
  assign acc_fault = lkp_valid_i & cam_hit & viol;
  assign acc_miss  = lkp_valid_i & ~cam_hit;
  assign fill_go   = fill_valid_i & ~flush_i;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_touch
    assign touch[i] = acc_ok && (cam_idx == IDX_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      use_q   <= '0;
      dirty_q <= '0;
      perm_q  <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_i) begin
          valid_q[i] <= 1'b0;
          use_q[i]   <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else if (fill_go && (vic_idx == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          vpn_q[i]   <= fill_vpn_i;
          ppn_q[i]   <= fill_ppn_i;
          perm_q[i]  <= '{sup: fill_sup_i, ro: fill_ro_i};
          use_q[i]   <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else begin
          use_q[i]   <= (use_q[i] & ~(fill_go & vic_clr)) | touch[i];
          dirty_q[i] <= dirty_q[i] | (touch[i] & lkp_write_i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_hit_o     <= 1'b0;
      rsp_miss_o    <= 1'b0;
      rsp_fault_o   <= 1'b0;
      rsp_paddr_o   <= '0;
      fill_ack_o    <= 1'b0;
      fill_slot_o   <= '0;
      evict_o       <= 1'b0;
      evict_vpn_o   <= '0;
      evict_ref_o   <= 1'b0;
      evict_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= lkp_valid_i;
      rsp_hit_o   <= acc_ok;
      rsp_miss_o  <= acc_miss;
      rsp_fault_o <= acc_fault;
      rsp_paddr_o <= acc_ok ? {ppn_q[cam_idx], lkp_vaddr_i[OFF_W-1:0]} : '0;
      fill_ack_o  <= fill_go;
      if (fill_go) begin
        fill_slot_o   <= vic_idx;
        evict_o       <= valid_q[vic_idx];
        evict_vpn_o   <= vpn_q[vic_idx];
        evict_ref_o   <= use_q[vic_idx];
        evict_dirty_o <= dirty_q[vic_idx];
      end
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned OFF_W   = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     lkp_valid_i,
  input logic [VPN_W+OFF_W-1:0]   lkp_vaddr_i,
  input logic                     fill_valid_i,
  input logic                     flush_i,
  input logic                     rsp_valid_o,
  input logic                     rsp_hit_o,
  input logic                     rsp_miss_o,
  input logic                     rsp_fault_o,
  input logic [PPN_W+OFF_W-1:0]   rsp_paddr_o,
  input logic                     fill_ack_o,
  input logic [ENTRIES-1:0]       valid_q
);
  p_one_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot({rsp_hit_o, rsp_miss_o, rsp_fault_o}));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_fault_o));

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> rsp_valid_o);

  p_offset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lkp_valid_i) && rsp_hit_o |-> rsp_paddr_o[OFF_W-1:0] == $past(lkp_vaddr_i[OFF_W-1:0]));

  p_miss_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> rsp_paddr_o == '0);

  p_fault_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_paddr_o == '0);

  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0 && !fill_ack_o);

  p_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ack_o |-> $past(fill_valid_i));
endmodule

bind tlb_fa tlb_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
) i_tlb_chk (.*);

// File: tb/test_tlb_fa.sv
module test_tlb_fa;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        lkp_valid = 0, lkp_write = 0, lkp_user = 0;
  logic [31:0] lkp_vaddr = '0;
  logic        fill_valid = 0, fill_sup = 0, fill_ro = 0, flush = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_ack, evict, evict_ref, evict_dirty;
  logic [3:0]  fill_slot;
  logic [19:0] evict_vpn;

  tlb_fa i_tlb_fa (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vaddr_i(lkp_vaddr), .lkp_write_i(lkp_write), .lkp_user_i(lkp_user),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_sup_i(fill_sup), .fill_ro_i(fill_ro), .flush_i(flush),
    .fill_ack_o(fill_ack), .fill_slot_o(fill_slot), .evict_o(evict),
    .evict_vpn_o(evict_vpn), .evict_ref_o(evict_ref), .evict_dirty_o(evict_dirty)
  );

  int checks = 0, errors = 0;

  // reference table
  bit        m_val [N];
  bit [19:0] m_vpn [N];
  bit [19:0] m_ppn [N];
  bit        m_sup [N], m_ro [N], m_use [N], m_dty [N];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find(input bit [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int pick(output bit clr);
    clr = 0;
    for (int i = 0; i < N; i++) if (!m_val[i]) return i;
    for (int i = 0; i < N; i++) if (!m_use[i]) return i;
    clr = 1;
    return 0;
  endfunction

  task automatic lookup(input bit [31:0] va, input bit wr, input bit us);
    int  k;
    bit  f;
    bit [31:0] ep;
    @(negedge clk);
    lkp_vaddr = va; lkp_write = wr; lkp_user = us; lkp_valid = 1;
    @(negedge clk);
    lkp_valid = 0;
    k = find(va[31:12]);
    check(rsp_valid === 1'b1, "R4", rsp_valid, 1);
    if (k < 0) begin
      check(rsp_miss === 1 && rsp_hit === 0 && rsp_fault === 0, "R2", {rsp_hit, rsp_miss, rsp_fault}, 3'b010);
      check(rsp_paddr === 0, "R2", rsp_paddr, 0);
    end else begin
      f = (m_sup[k] && us) || (m_ro[k] && wr);
      if (f) begin
        check(rsp_fault === 1 && rsp_hit === 0 && rsp_miss === 0, "R3", {rsp_hit, rsp_miss, rsp_fault}, 3'b001);
        check(rsp_paddr === 0, "R3", rsp_paddr, 0);
      end else begin
        ep = {m_ppn[k], va[11:0]};
        check(rsp_hit === 1 && rsp_miss === 0 && rsp_fault === 0, "R1", {rsp_hit, rsp_miss, rsp_fault}, 3'b100);
        check(rsp_paddr === ep, "R1", rsp_paddr, ep);
        m_use[k] = 1;
        if (wr) m_dty[k] = 1;
      end
    end
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [19:0] ppn, input bit sp, input bit r, input string req);
    int v;
    bit clr;
    @(negedge clk);
    fill_vpn = vpn; fill_ppn = ppn; fill_sup = sp; fill_ro = r; fill_valid = 1;
    @(negedge clk);
    fill_valid = 0;
    v = pick(clr);
    check(rsp_valid === 0 && rsp_hit === 0 && rsp_miss === 0 && rsp_fault === 0, "R4",
          {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
    check(fill_ack === 1, "R9", fill_ack, 1);
    check(fill_slot === 4'(v), req, fill_slot, v);
    check(evict === m_val[v], "R9", evict, m_val[v]);
    if (m_val[v]) begin
      check(evict_vpn === m_vpn[v], "R9", evict_vpn, m_vpn[v]);
      check(evict_ref === m_use[v], "R5", evict_ref, m_use[v]);
      check(evict_dirty === m_dty[v], "R5", evict_dirty, m_dty[v]);
    end
    if (clr) for (int i = 0; i < N; i++) m_use[i] = 0;
    m_val[v] = 1; m_vpn[v] = vpn; m_ppn[v] = ppn; m_sup[v] = sp; m_ro[v] = r;
    m_use[v] = 0; m_dty[v] = 0;
  endtask

  task automatic do_flush(input bit with_fill);
    @(negedge clk);
    flush = 1; fill_valid = with_fill; fill_vpn = 20'h0beef;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    check(fill_ack === 0, "R10", fill_ack, 0);
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_use[i] = 0; m_dty[i] = 0; end
  endtask

  function automatic bit [19:0] pool(input int k);
    return 20'h40000 + 20'(k * 37);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [19:0] v;
    void'($urandom(32'd7321));
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_use[i] = 0; m_dty[i] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_ack, evict} === 6'b0 && rsp_paddr === 0,
          "R11", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
    rst_n = 1;
    lookup(32'h1234_5678, 0, 1);                  // R11: empty table misses

    // R6: fill empty slots in order
    for (int i = 0; i < N; i++) fill(pool(i), 20'h80000 + 20'(i), 0, 0, "R6");
    for (int i = 0; i < N; i++) if (i != 5) lookup({pool(i), 12'(i * 3)}, (i == 2), 0);
    // R7: slot 5 unused
    fill(pool(20), 20'h0aaaa, 1, 0, "R7");
    lookup({pool(20), 12'h010}, 0, 1);            // R3 supervisor-only from user
    lookup({pool(20), 12'h020}, 0, 0);            // R1 supervisor read
    // R8: all used, clear and take slot 0
    fill(pool(21), 20'h0bbbb, 0, 1, "R8");
    lookup({pool(21), 12'h004}, 1, 0);            // R3 read-only write
    lookup({pool(21), 12'h008}, 0, 1);            // R1 read-only read
    fill(pool(22), 20'h0cccc, 0, 0, "R7");        // slot 1 after aging
    fill(pool(23), 20'h0dddd, 0, 0, "R7");        // slot 2: dirty write from earlier
    // R10 flush, then flush with simultaneous fill
    do_flush(0);
    lookup({pool(0), 12'h0}, 0, 0);
    do_flush(1);
    lookup({20'h0beef, 12'h0}, 0, 0);
    fill(pool(3), 20'h00333, 0, 0, "R6");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom % 20);
      v  = pool(int'($urandom % 28));
      if (op < 12) lookup({v, 12'($urandom)}, 1'($urandom), 1'($urandom));
      else if (op < 19) begin
        if (find(v) < 0) fill(v, 20'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, "R7");
        else lookup({v, 12'($urandom)}, 1'($urandom), 0);
      end else if ($urandom % 6 == 0) do_flush(1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule